// File: doc/BRIEF.md
# Integer-N Loop Divider, Phase Detector and Lock Monitor

This block is the digital heart of an integer-N frequency synthesiser loop. Two pulse inputs arrive as single-cycle strobes in the system clock domain. One marks each edge of the reference oscillator and the other each edge of the VCO after an external divide-by-16 prescaler. A fixed reference divider turns the reference strobe into the comparison tick. A 15-bit programmable divider turns the prescaled VCO strobe into the divided tick. With the default reference division of 512, a 4 MHz reference gives a 7.8125 kHz comparison rate, and the locked output frequency is ratio × 16 × Fcomp.

A phase-frequency detector compares the two ticks and drives pump-up and pump-down requests for an external charge pump. A lock monitor raises a flag after a run of well-aligned comparison periods. Four control bits are registered into the block:
- pump-current select, passed out as a select line;
- pump disable, which silences both pump requests;
- drive-amplifier off, passed out as a line;
- test enable, which puts the two compared ticks on test outputs.

Top module: `pll_core`

## Requirements
- R1: The comparison tick fires on every REF_DIV-th reference pulse, counted from reset (default 512, so 4 MHz gives 7.8125 kHz).
- R2: The divided tick fires on every max(ratio, 1)-th prescaled VCO pulse. The ratio is 15 bits wide and unsigned, so the locked output frequency is ratio × 16 × Fcomp.
- R3: A new ratio on `ratio_i` takes effect only after the divided period in progress ends. The period that is running completes with the old ratio.
- R4: A ratio of 0 is treated as ratio 1, so every prescaled pulse produces a divided tick.
- R5: Phase-detector rules:
  - A comparison tick sets the up request.
  - A divided tick sets the down request.
  - When both would be set, both clear.
  - Coincident ticks leave both low.
  - `up_o` and `dn_o` are never high together.
- R6: With `pump_off_i` = 1 at a clock edge, `up_o` and `dn_o` are 0 after that edge. The detector state is kept and reappears once `pump_off_i` returns to 0.
- R7: `cur_sel_o` and `drv_off_o` equal `cur_hi_i` and `drv_off_i` sampled at the previous clock edge.
- R8: With `test_en_i` = 1, `tst_ref_o` and `tst_div_o` are high for the one cycle after the edge that took a comparison tick and a divided tick respectively. With `test_en_i` = 0 they stay 0.
- R9: `lock_o` rises after LOCK_CYC consecutive good comparison periods. A period is good when at least one divided tick arrived since the previous comparison tick (the current cycle included) and the phase error lasted at most WIN clock cycles.
- R10: A single comparison period that is not good clears `lock_o` at the edge that evaluates it.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse_i | input | 1 | One strobe per reference oscillator edge |
| vco_pulse_i | input | 1 | One strobe per prescaled VCO edge |
| ratio_i | input | RATIO_W | Programmable division ratio |
| cur_hi_i | input | 1 | 1 selects the high pump current |
| pump_off_i | input | 1 | 1 disables both pump requests |
| drv_off_i | input | 1 | 1 switches off the drive amplifier |
| test_en_i | input | 1 | 1 routes the compared ticks to the test outputs |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| cur_sel_o | output | 1 | Registered current select |
| drv_off_o | output | 1 | Registered drive-off line |
| lock_o | output | 1 | Lock flag |
| tst_ref_o | output | 1 | Comparison tick test output |
| tst_div_o | output | 1 | Divided tick test output |

## Verification
The assertions assume that the two pulse inputs are already clean single-cycle strobes in the clock domain. They also assume that `ratio_i` is held steady through reset, because the first active ratio is taken from it there. The bench meets both assumptions:
- it changes every input only at the falling clock edge;
- it never raises a strobe for longer than one cycle;
- it holds the ratio fixed during each reset.

Divider sweeps run over ratios 0 to 9 with a reference division of 4. The expected tick positions come from simple counting in the bench.

// File: rtl/pll_pkg.sv
package pll_pkg;

    typedef struct packed {
        logic cur_hi;
        logic pump_off;
        logic drv_off;
        logic test_en;
    } ctl_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_t;

endpackage

// File: rtl/ref_div.sv
module ref_div #(
    parameter int REF_DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic tick_o
);
    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = pulse_i && (cnt_q == LAST);
        if (pulse_i) begin
            cnt_d = tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/prog_div.sv
module prog_div #(
    parameter int RATIO_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o,
    output logic [RATIO_W-1:0] active_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] act;
    } st_t;

    st_t d, q;
    logic [RATIO_W-1:0] legal;

    always_comb begin
        legal    = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
        d        = q;
        tick_o   = pulse_i && (q.cnt == q.act - 1'b1);
        active_o = q.act;
        if (pulse_i) begin
            if (tick_o) begin
                d.cnt = '0;
                d.act = legal;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.act <= legal;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic div_tick_i,
    output pfd_t state_o
);
    pfd_t d, q;

    always_comb begin
        d.up = q.up | ref_tick_i;
        d.dn = q.dn | div_tick_i;
        if (d.up && d.dn) begin
            d.up = 1'b0;
            d.dn = 1'b0;
        end
        state_o = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lock_det.sv
module lock_det #(
    parameter int LOCK_CYC = 4,
    parameter int WIN      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic div_tick_i,
    input  logic phase_err_i,
    output logic good_o,
    output logic lock_o
);
    localparam int ERR_W = $clog2(WIN + 2);
    localparam int RUN_W = $clog2(LOCK_CYC + 1);
    localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(WIN + 1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             seen;
        logic [RUN_W-1:0] run;
        logic             lock;
    } st_t;

    st_t d, q;

    always_comb begin
        d      = q;
        good_o = (q.seen || div_tick_i) && (q.err <= ERR_W'(WIN));
        if (!ref_tick_i) begin
            d.seen = q.seen | div_tick_i;
            if (phase_err_i && q.err != ERR_SAT) d.err = q.err + 1'b1;
        end else begin
            d.err  = '0;
            d.seen = 1'b0;
            if (good_o) begin
                if (q.lock || q.run == RUN_W'(LOCK_CYC - 1)) d.lock = 1'b1;
                else                                         d.run  = q.run + 1'b1;
            end else begin
                d.run  = '0;
                d.lock = 1'b0;
            end
        end
        lock_o = q.lock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pll_core.sv
module pll_core
    import pll_pkg::*;
#(
    parameter int RATIO_W  = 15,
    parameter int REF_DIV  = 512,
    parameter int LOCK_CYC = 4,
    parameter int WIN      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_pulse_i,
    input  logic               vco_pulse_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               cur_hi_i,
    input  logic               pump_off_i,
    input  logic               drv_off_i,
    input  logic               test_en_i,
    output logic               up_o,
    output logic               dn_o,
    output logic               cur_sel_o,
    output logic               drv_off_o,
    output logic               lock_o,
    output logic               tst_ref_o,
    output logic               tst_div_o
);
    typedef struct packed {
        ctl_t ctl;
        logic tref;
        logic tdiv;
    } top_t;

    logic               ref_tick, div_tick, win_good;
    logic [RATIO_W-1:0] act_ratio;
    pfd_t               pfd_st;
    top_t               d, q;

    ref_div #(.REF_DIV(REF_DIV)) u_ref (
        .clk(clk), .rst_n(rst_n), .pulse_i(ref_pulse_i), .tick_o(ref_tick)
    );

    prog_div #(.RATIO_W(RATIO_W)) u_div (
        .clk(clk), .rst_n(rst_n), .pulse_i(vco_pulse_i), .ratio_i(ratio_i),
        .tick_o(div_tick), .active_o(act_ratio)
    );

    pfd_core u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .div_tick_i(div_tick),
        .state_o(pfd_st)
    );

    lock_det #(.LOCK_CYC(LOCK_CYC), .WIN(WIN)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .div_tick_i(div_tick),
        .phase_err_i(pfd_st.up | pfd_st.dn), .good_o(win_good), .lock_o(lock_o)
    );

    always_comb begin
        d.ctl.cur_hi   = cur_hi_i;
        d.ctl.pump_off = pump_off_i;
        d.ctl.drv_off  = drv_off_i;
        d.ctl.test_en  = test_en_i;
        d.tref         = test_en_i & ref_tick;
        d.tdiv         = test_en_i & div_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_o      = pfd_st.up & ~q.ctl.pump_off;
    assign dn_o      = pfd_st.dn & ~q.ctl.pump_off;
    assign cur_sel_o = q.ctl.cur_hi;
    assign drv_off_o = q.ctl.drv_off;
    assign tst_ref_o = q.tref;
    assign tst_div_o = q.tdiv;
endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk #(
    parameter int RATIO_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cur_hi_i,
    input logic               pump_off_i,
    input logic               drv_off_i,
    input logic               test_en_i,
    input logic               up_o,
    input logic               dn_o,
    input logic               cur_sel_o,
    input logic               drv_off_o,
    input logic               lock_o,
    input logic               tst_ref_o,
    input logic               tst_div_o,
    input logic               ref_tick,
    input logic               div_tick,
    input logic               win_good,
    input logic [RATIO_W-1:0] act_ratio
);
    assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !div_tick |=> $stable(act_ratio));

    assert_pfd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_o, dn_o}));

    assert_pump_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pump_off_i |=> (!up_o && !dn_o));

    assert_cur_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_hi_i |=> cur_sel_o);

    assert_drv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_off_i |=> !drv_off_o);

    assert_test_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_i |=> (!tst_ref_o && !tst_div_o));

    assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o && !ref_tick |=> !lock_o);

    assert_lock_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick && !win_good |=> !lock_o);
endmodule

bind pll_core pll_core_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_hi_i(cur_hi_i), .pump_off_i(pump_off_i),
    .drv_off_i(drv_off_i), .test_en_i(test_en_i), .up_o(up_o), .dn_o(dn_o),
    .cur_sel_o(cur_sel_o), .drv_off_o(drv_off_o), .lock_o(lock_o),
    .tst_ref_o(tst_ref_o), .tst_div_o(tst_div_o), .ref_tick(ref_tick),
    .div_tick(div_tick), .win_good(win_good), .act_ratio(act_ratio)
);

// File: tb/tb_pll_core.sv
module tb_pll_core;
    localparam int RW = 15;
    localparam int RD = 4;
    localparam int LC = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          ref_p = 0, vco_p = 0;
    logic [RW-1:0] ratio = 4;
    logic          cp = 0, poff = 0, doff = 0, ten = 0;
    logic          up, dn, csel, dro, lock, tref, tdiv;
    int            total = 0, bad = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    pll_core #(.RATIO_W(RW), .REF_DIV(RD), .LOCK_CYC(LC), .WIN(2)) dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .vco_pulse_i(vco_p),
        .ratio_i(ratio), .cur_hi_i(cp), .pump_off_i(poff), .drv_off_i(doff),
        .test_en_i(ten), .up_o(up), .dn_o(dn), .cur_sel_o(csel),
        .drv_off_o(dro), .lock_o(lock), .tst_ref_o(tref), .tst_div_o(tdiv)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(logic r, logic v);
        @(negedge clk);
        ref_p = r;
        vco_p = v;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        ref_p = 0;
        vco_p = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        do_reset();
        // R11 reset state
        check("R11 outputs", {up, dn, csel, dro, lock, tref, tdiv}, 0);

        // R9 lock after LC aligned periods; R5 coincident ticks keep requests low
        for (int s = 1; s <= 12; s++) begin
            step(1, 1);
            check("R5 coincident up", up, 0);
            check("R5 coincident dn", dn, 0);
            check("R9 lock timing", lock, (s >= 4 * LC) ? 1 : 0);
        end
        // R10 single missing divided tick drops lock
        for (int s = 13; s <= 16; s++) begin
            step(1, 0);
            check("R10 lock drop", lock, (s < 16) ? 1 : 0);
        end
        check("R5 ref tick sets up", up, 1);
        check("R5 ref tick no dn", dn, 0);
        // R6 pump disable masks and preserves state
        poff = 1;
        step(0, 0);
        check("R6 up masked", up, 0);
        poff = 0;
        step(0, 0);
        check("R6 up restored", up, 1);
        // R5 divided tick clears both
        for (int s = 1; s <= 4; s++) begin
            step(0, 1);
            check("R5 up until div", up, (s < 4) ? 1 : 0);
            check("R5 dn stays low", dn, 0);
        end
        for (int s = 1; s <= 4; s++) begin
            step(0, 1);
            check("R5 dn on div", dn, (s == 4) ? 1 : 0);
            check("R5 up low", up, 0);
        end
        // R7 current select and drive off
        cp = 1; doff = 1;
        step(0, 0);
        check("R7 cur_sel", csel, 1);
        check("R7 drv_off", dro, 1);
        cp = 0;
        step(0, 0);
        check("R7 cur_sel low", csel, 0);
        check("R7 drv_off held", dro, 1);
        doff = 0;
        step(0, 0);
        check("R7 drv_off low", dro, 0);

        // R1 reference division with gaps; R8 test output
        ratio = 4;
        do_reset();
        ten = 1;
        for (int s = 1; s <= 24; s++) begin
            step((s % 2) == 0, 0);
            check("R1 ref tick", tref, (s % (2 * RD) == 0) ? 1 : 0);
            check("R8 div quiet", tdiv, 0);
        end

        // R3 ratio change after current period
        do_reset();
        for (int s = 1; s <= 18; s++) begin
            ratio = (s >= 10) ? 6 : 4;
            step(0, 1);
            check("R3 load at terminal", tdiv,
                  (s == 4 || s == 8 || s == 12 || s == 18) ? 1 : 0);
        end

        // R2 / R4 sweep over ratios 0..9
        for (int r = 0; r <= 9; r++) begin
            int eff;
            int n;
            eff = (r == 0) ? 1 : r;
            ratio = RW'(r);
            n = 0;
            do begin
                step(0, 1);
                n++;
            end while (!tdiv && n < 40);
            for (int k = 0; k < 3; k++) begin
                n = 0;
                do begin
                    step(0, 1);
                    n++;
                end while (!tdiv && n < 40);
                if (r == 0) check("R4 zero ratio period", n, eff);
                else        check("R2 divided period", n, eff);
            end
        end

        // R8 test disabled keeps outputs quiet
        ten = 0;
        ratio = 1;
        for (int s = 1; s <= 8; s++) begin
            step(1, 1);
            check("R8 quiet ref", tref, 0);
            check("R8 quiet div", tdiv, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule